// File: doc/BRIEF.md
# Hours Counter with 12/24-Hour BCD Format

This block holds the hours field of a real-time clock as one BCD byte. A format input chooses between a 24-hour count (00 to 23) and a 12-hour count (1 to 12, with a PM flag in the top bit). Each pulse on the minute-carry input advances the hour by one. Rolling past midnight produces a one-cycle day-carry pulse for the date logic. Software can overwrite the byte with a parallel load.

When the format input changes level, the stored hour is re-encoded into the new format on that same clock edge. The time of day does not change. Software can therefore switch formats at any time without reprogramming the hour. Both the hour byte and the day carry come from registers.

Top module: `rtc_hour_ctr`

## Requirements
- R1: With fmt_24h = 1, each minute carry advances hour_q by one through BCD values 0x00 to 0x23. From 0x23 it wraps to 0x00, and day_carry is 1 for exactly the cycle in which hour_q first shows 0x00.
- R2: With fmt_24h = 0, hour_q bit 7 is the PM flag and bits 6..0 hold a BCD hour from 1 to 12. On a minute carry: 11 AM (0x11) becomes 12 PM (0x92), 12 PM (0x92) becomes 1 PM (0x81), and 11 PM (0x91) becomes 12 AM (0x12) with day_carry = 1.
- R3: When fmt_24h falls from 1 to 0, the stored 24-hour value is re-encoded on that edge. Values 12 to 23 lose 12 and get the PM flag set. Value 0 becomes 0x12 with PM clear. Values 1 to 11 are kept with PM clear.
- R4: When fmt_24h rises from 0 to 1, bits 6..4 are read as tens and bits 3..0 as units. If the value is below 12 and PM is set, 12 is added. If the value is 12 and PM is clear, the result is 0x00. The result is stored as a 24-hour BCD byte.
- R5: When load_en is 1, load_val appears on hour_q after the next clock edge, exactly as written, and day_carry is 0. This wins over a minute carry and over a format change in the same cycle.
- R6: An invalid stored byte is advanced as follows on the next minute carry:
  - In 24-hour mode the byte is read as tens×10 + units and advanced by one. Any value of 23 or more goes to 0x00 with day_carry.
  - In 12-hour mode, values below 11 go up by one.
  - In 12-hour mode, values of 12 or more go to 1 and keep the PM flag.
- R7: When a format change and a minute carry fall in the same cycle, the hour is first re-encoded and then advanced in the new format.
- R8: A synchronous reset sets hour_q to midnight in the current format (0x00 if fmt_24h = 1, 0x12 if fmt_24h = 0) and clears day_carry. With no load, no minute carry and no format change, hour_q holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_24h | input | 1 | Format select: 1 = 24-hour, 0 = 12-hour |
| min_carry | input | 1 | One-cycle pulse: advance the hour |
| load_en | input | 1 | Parallel load strobe |
| load_val | input | 8 | Hour byte to load |
| hour_q | output | 8 | Stored hour byte in the current format |
| day_carry | output | 1 | One-cycle pulse on rollover past midnight |

## Verification
Every result of this block, including the loaded byte, the re-encoded hour, the advanced hour and the day carry, sits behind one register stage. Each therefore shows up exactly one clock edge after the inputs that cause it. The bench drives each vector on a falling edge and samples hour_q and day_carry on the following falling edge, after exactly one rising edge. Because the value is read in mid-period, a one-cycle carry pulse is seen in the single cycle it is due, and a pulse that lasts too long is caught by the check on the next vector. Reset values and the hold behaviour are checked by directed steps after the vector walk, using the same one-edge timing.

// File: rtl/rtc_hour_pkg.sv
package rtc_hour_pkg;
  localparam int HOUR_W   = 8;
  localparam int NIB_W    = 4;
  localparam int VAL_W    = 8;
  localparam int HOURS_DAY = 24;
  localparam int HOURS_HALF = 12;

  typedef logic [HOUR_W-1:0] hour_t;
  typedef logic [VAL_W-1:0]  hval_t;

  // BCD nibbles to binary value
  function automatic hval_t bcd_to_val(input logic [NIB_W-1:0] tens,
                                       input logic [NIB_W-1:0] units);
    hval_t t10;
    t10 = hval_t'(tens) * hval_t'(10);
    return t10 + hval_t'(units);
  endfunction

  // binary value (below 160) to BCD byte
  function automatic hour_t val_to_bcd(input hval_t v);
    hval_t t;
    hval_t u;
    t = v / hval_t'(10);
    u = v % hval_t'(10);
    return {t[NIB_W-1:0], u[NIB_W-1:0]};
  endfunction
endpackage

// File: rtl/rtc_hour_conv.sv
module rtc_hour_conv
  import rtc_hour_pkg::*;
#(
  parameter bit TO_24 = 1'b1
) (
  input  hour_t hour_in,
  output hour_t hour_out
);
  generate
    if (TO_24) begin : g_to24
      // 12-hour byte in, 24-hour byte out
      always_comb begin
        hval_t v;
        v = bcd_to_val({1'b0, hour_in[6:4]}, hour_in[3:0]);
        if (hour_in[7] && v < hval_t'(HOURS_HALF))
          v = v + hval_t'(HOURS_HALF);
        else if (!hour_in[7] && v == hval_t'(HOURS_HALF))
          v = '0;
        hour_out = val_to_bcd(v);
      end
    end else begin : g_to12
      // 24-hour byte in, 12-hour byte out
      always_comb begin
        hval_t v;
        logic  pm;
        hour_t enc;
        v  = bcd_to_val(hour_in[7:4], hour_in[3:0]);
        pm = (v > hval_t'(HOURS_HALF - 1));
        if (pm) v = v - hval_t'(HOURS_HALF);
        if (v == '0) v = hval_t'(HOURS_HALF);
        enc = val_to_bcd(v);
        hour_out = {pm, enc[6:0]};
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_hour_pkg::*;
(
  input  hour_t hour_in,
  input  logic  fmt_24h,
  output hour_t hour_out,
  output logic  wrap
);
  hval_t v24;
  hval_t v12;
  hour_t enc24;
  hour_t enc12;

  always_comb begin
    v24   = bcd_to_val(hour_in[7:4], hour_in[3:0]);
    v12   = bcd_to_val({1'b0, hour_in[6:4]}, hour_in[3:0]);
    enc24 = val_to_bcd(v24 + hval_t'(1));
    enc12 = val_to_bcd(v12 + hval_t'(1));
    hour_out = hour_in;
    wrap     = 1'b0;
    if (fmt_24h) begin
      if (v24 >= hval_t'(HOURS_DAY - 1)) begin
        hour_out = '0;
        wrap     = 1'b1;
      end else begin
        hour_out = enc24;
      end
    end else begin
      if (v12 == hval_t'(HOURS_HALF - 1)) begin
        // 11 -> 12, meridian flips; PM->AM is the midnight rollover
        hour_out = {~hour_in[7], 7'h12};
        wrap     = hour_in[7];
      end else if (v12 >= hval_t'(HOURS_HALF)) begin
        hour_out = {hour_in[7], 7'h01};
      end else begin
        hour_out = {hour_in[7], enc12[6:0]};
      end
    end
  end
endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr
  import rtc_hour_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fmt_24h,
  input  logic       min_carry,
  input  logic       load_en,
  input  logic [7:0] load_val,
  output logic [7:0] hour_q,
  output logic       day_carry
);
  localparam hour_t MIDNIGHT_24 = 8'h00;
  localparam hour_t MIDNIGHT_12 = 8'h12;

  logic  fmt_q;
  hour_t as24, as12, base, stepped;
  logic  step_wrap;
  logic  fmt_chg;

  rtc_hour_conv #(.TO_24(1'b1)) u_to24 (.hour_in(hour_q), .hour_out(as24));
  rtc_hour_conv #(.TO_24(1'b0)) u_to12 (.hour_in(hour_q), .hour_out(as12));

  assign fmt_chg = (fmt_24h != fmt_q);

  always_comb begin
    if (fmt_chg) base = fmt_24h ? as24 : as12;
    else         base = hour_q;
  end

  rtc_hour_step u_step (
    .hour_in (base),
    .fmt_24h (fmt_24h),
    .hour_out(stepped),
    .wrap    (step_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hour_q    <= fmt_24h ? MIDNIGHT_24 : MIDNIGHT_12;
      fmt_q     <= fmt_24h;
      day_carry <= 1'b0;
    end else begin
      fmt_q <= fmt_24h;
      if (load_en) begin
        hour_q    <= load_val;
        day_carry <= 1'b0;
      end else if (min_carry) begin
        hour_q    <= stepped;
        day_carry <= step_wrap;
      end else begin
        hour_q    <= base;
        day_carry <= 1'b0;
      end
    end
  end

  // R5
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (hour_q == $past(load_val) && !day_carry));

  // R1
  carry_cause_chk: assert property (@(posedge clk) disable iff (rst)
    day_carry |-> ($past(min_carry) && !$past(load_en)));

  // R1
  carry24_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (day_carry && fmt_q) |-> (hour_q == MIDNIGHT_24));

  // R2
  carry12_am_chk: assert property (@(posedge clk) disable iff (rst)
    (day_carry && !fmt_q) |-> (hour_q == MIDNIGHT_12));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !min_carry && fmt_24h == fmt_q) |=> $stable(hour_q));

  // R6
  step12_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (min_carry && !load_en && !fmt_24h) |=> (hour_q[6:5] == 2'b00));
endmodule

// File: tb/rtc_hour_ctr_bench.sv
module rtc_hour_ctr_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       fmt_24h;
  logic       min_carry;
  logic       load_en;
  logic [7:0] load_val;
  logic [7:0] hour_q;
  logic       day_carry;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rtc_hour_ctr u_rtc_hour_ctr (
    .clk(clk), .rst(rst), .fmt_24h(fmt_24h), .min_carry(min_carry),
    .load_en(load_en), .load_val(load_val), .hour_q(hour_q), .day_carry(day_carry)
  );

  // {fmt, load_en, load_val, min_carry, expected hour, expected carry}
  localparam int NV = 25;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h09, 1'b0, 8'h09, 1'b0},  // R5 load
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h10, 1'b0},  // R1 BCD tens carry
    {1'b1, 1'b1, 8'h23, 1'b0, 8'h23, 1'b0},  // R5
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1},  // R1 wrap with carry
    {1'b1, 1'b1, 8'h11, 1'b1, 8'h11, 1'b0},  // R5 load beats step
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h11, 1'b0},  // R3 11 -> 11 AM
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h92, 1'b0},  // R2 11 AM -> 12 PM
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h81, 1'b0},  // R2 12 PM -> 1 PM
    {1'b1, 1'b0, 8'h00, 1'b0, 8'h13, 1'b0},  // R4 1 PM -> 13
    {1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0},  // R5
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h12, 1'b0},  // R3 0 -> 12 AM
    {1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},  // R4 12 AM -> 0
    {1'b1, 1'b1, 8'h12, 1'b0, 8'h12, 1'b0},  // R5
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h92, 1'b0},  // R3 12 -> 12 PM
    {1'b1, 1'b0, 8'h00, 1'b0, 8'h12, 1'b0},  // R4 12 PM -> 12
    {1'b0, 1'b1, 8'h91, 1'b0, 8'h91, 1'b0},  // R5 load beats conversion
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h12, 1'b1},  // R2 11 PM -> 12 AM carry
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h01, 1'b0},  // R2 12 AM -> 1 AM
    {1'b0, 1'b1, 8'h0A, 1'b0, 8'h0A, 1'b0},  // R6 invalid kept
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0},  // R6 10 -> 11
    {1'b1, 1'b1, 8'h2F, 1'b0, 8'h2F, 1'b0},  // R6 invalid kept
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1},  // R6 35 -> 00 carry
    {1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},  // R8 hold, carry gone
    {1'b0, 1'b0, 8'h00, 1'b1, 8'h01, 1'b0},  // R7 convert then step
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h02, 1'b0}   // R7 convert then step
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; fmt_24h = 1'b1; min_carry = 1'b0; load_en = 1'b0; load_val = '0;
    tick; tick;
    chk("R8 reset hour 24h", hour_q, 8'h00);
    chk("R8 reset carry", {7'd0, day_carry}, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      fmt_24h   = VEC[i][19];
      load_en   = VEC[i][18];
      load_val  = VEC[i][17:10];
      min_carry = VEC[i][9];
      tick;
      chk($sformatf("vector %0d hour", i), hour_q, VEC[i][8:1]);
      chk($sformatf("vector %0d carry", i), {7'd0, day_carry}, {7'd0, VEC[i][0]});
    end
    load_en = 1'b0; min_carry = 1'b0;
    // R8: reset in 12-hour format, minute carry ignored during reset
    rst = 1'b1; fmt_24h = 1'b0; min_carry = 1'b1;
    tick;
    chk("R8 reset hour 12h", hour_q, 8'h12);
    chk("R8 reset carry 12h", {7'd0, day_carry}, 8'h00);
    rst = 1'b0; min_carry = 1'b0;
    tick; tick; tick;
    chk("R8 hold 12h", hour_q, 8'h12);
    // R2: step through a half day in 12-hour mode
    min_carry = 1'b1;
    for (int k = 0; k < 11; k++) tick;
    min_carry = 1'b0;
    chk("R2 eleven steps from 12 AM", hour_q, 8'h11);
    min_carry = 1'b1;
    tick;
    min_carry = 1'b0;
    chk("R2 noon", hour_q, 8'h92);
    chk("R2 no carry at noon", {7'd0, day_carry}, 8'h00);
    // R1: full 24-hour day in 24-hour mode
    rst = 1'b1; fmt_24h = 1'b1;
    tick;
    rst = 1'b0; min_carry = 1'b1;
    for (int k = 0; k < 23; k++) tick;
    chk("R1 reached 23", hour_q, 8'h23);
    chk("R1 no early carry", {7'd0, day_carry}, 8'h00);
    tick;
    min_carry = 1'b0;
    chk("R1 day wrap", hour_q, 8'h00);
    chk("R1 day carry", {7'd0, day_carry}, 8'h01);
    tick;
    chk("R1 carry single cycle", {7'd0, day_carry}, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule